// File: doc/BRIEF.md
# T1 Transmit Elastic Store

This block sits between a system backplane and a T1 line framer on the transmit path. It takes serial data from the system side and sends it out as a 193-bit frame stream on the line side. The two sides run at independent rates, and the block absorbs the difference in a buffer that holds two frames (386 bits). Each side is modelled as a strobe on a shared clock: `wr_en_i` marks a system bit and `rd_en_i` marks a line bit.

The system side can run in one of two modes. In narrow mode (`mode_2m_i` = 0) it carries 193-bit frames with the framing bit first. In wide mode (`mode_2m_i` = 1) it carries 256-bit frames of 32 eight-bit slots. In wide mode every fourth slot (0, 4, ..., 28) is dropped, except that the first bit of slot 0 becomes the framing bit. A channel-block output flags the dropped slots to the system side, and `sys_fsync_i` aligns each input frame.

When the buffer would overflow, the block drops a whole incoming frame. When it would underflow, it repeats the last line frame. Each such slip raises a sticky flag and a sticky flag for the direction. A separate control puts the two pointers back into opposite frames.

Top module: `tx_elastic_store`

## Requirements
- R1: After `rst_ni` the buffer is all zeros, the reader starts at bit 0 of frame 1 and the writer at bit 0 of frame 0, and one frame counts as unread. `line_fbit_o` is high for the first bit read and for every 193rd bit after it.
- R2: In narrow mode the input frame is 193 bits. The bit accepted with `sys_fsync_i` high is frame bit 0 (the framing bit), and the k-th bit after it is frame bit k. All bits are kept, and `chblk_o` stays low.
- R3: In wide mode the input frame is 256 bits, forming 32 slots of 8 bits sent in order. Slot s, bit b (s not a multiple of 4) becomes frame bit 1+8·(s−s/4−1)+b. Bit 0 of slot 0 becomes frame bit 0. All other bits of slots 0, 4, ..., 28 are discarded.
- R4: In wide mode `chblk_o` is high exactly when the next system bit to be accepted lies in slot 0, 4, 8, ..., 28.
- R5: `line_data_o` and `line_fbit_o` update on the clock edge that samples `rd_en_i` and hold their value while `rd_en_i` is low.
- R6: A full slip occurs when the writer completes a frame while more than 193 bits are unread. The completed frame is discarded and the writer refills the same frame. `slip_o` and `slip_full_o` are set.
- R7: An empty slip occurs when the reader completes a frame while fewer than 193 bits remain unread. The reader repeats the frame it has just sent. `slip_o` and `slip_empty_o` are set.
- R8: The three slip flags are sticky. `clr_i` clears them on the next edge, and a slip in the same cycle wins over the clear.
- R9: `es_reset_i` sends the writer to bit 0 of frame 0 and the reader to bit 0 of frame 1, with one frame counted as unread. Buffer contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_2m_i | input | 1 | 0: 193-bit system frame, 1: 32-slot system frame |
| wr_en_i | input | 1 | System bit strobe |
| sys_data_i | input | 1 | System serial data |
| sys_fsync_i | input | 1 | Marks the first bit of a system frame (with `wr_en_i`) |
| rd_en_i | input | 1 | Line bit strobe |
| es_reset_i | input | 1 | Re-centre the pointers in opposite frames |
| clr_i | input | 1 | Clear the sticky slip flags |
| line_data_o | output | 1 | Line serial data |
| line_fbit_o | output | 1 | High while `line_data_o` is a framing bit |
| chblk_o | output | 1 | Next system bit falls in a discarded slot |
| slip_o | output | 1 | Sticky: a slip occurred |
| slip_full_o | output | 1 | Sticky: a frame was discarded |
| slip_empty_o | output | 1 | Sticky: a frame was repeated |

## Verification
The bench uses the default parameters: a 193-bit line frame, 8-bit slots, 32 slots and a drop group of 4. These values make the wide-mode channel mapping match the real 32-slot layout, so every dropped slot and the framing-bit harvest are exercised bit for bit. With two frames of storage, a 2:1 rate mismatch in either direction forces a full or an empty slip within the first frame. This lets the bench predict the exact discard or repeat pattern over a few frames. Exact equal rates, and the 193/256 strobe ratio in wide mode, bring the reader's and the writer's frame completions into the same cycle. This is the boundary where the slip comparison must not fire.

// File: rtl/tx_es_pkg.sv
package tx_es_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int unsigned T1_FRAME_BITS = 193;
  localparam int unsigned SYS_SLOT_BITS = 8;
  localparam int unsigned SYS_NUM_SLOTS = 32;
  localparam int unsigned SYS_DROP_GROUP = 4;

  typedef struct packed {
    logic full;
    logic empty;
  } slip_evt_t;
endpackage

// File: rtl/tx_es_wr_map.sv
module tx_es_wr_map #(
  parameter int FRAME_BITS = 193,
  parameter int SLOT_BITS  = 8,
  parameter int NUM_SLOTS  = 32,
  parameter int GROUP      = 4,
  parameter int IW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          mode_2m_i,
  input  logic          wr_en_i,
  input  logic          fsync_i,
  output logic          store_o,
  output logic [IW-1:0] idx_o,
  output logic          chblk_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int WIDE_BITS = SLOT_BITS * NUM_SLOTS;
  localparam int MAX_LEN   = (WIDE_BITS > FRAME_BITS) ? WIDE_BITS : FRAME_BITS;
  localparam int PW        = $clog2(MAX_LEN);

  logic [PW-1:0] pos_q, cur_pos;
  int slot_n, bit_n, last_pos, nxt_slot;

  always_comb begin
    cur_pos  = fsync_i ? '0 : pos_q;
    slot_n   = int'(cur_pos) / SLOT_BITS;
    bit_n    = int'(cur_pos) % SLOT_BITS;
    last_pos = mode_2m_i ? WIDE_BITS - 1 : FRAME_BITS - 1;
    store_o  = 1'b0;
    idx_o    = '0;
    if (!mode_2m_i) begin
      store_o = wr_en_i;
      idx_o   = IW'(cur_pos);
    end else if ((slot_n % GROUP) == 0) begin
      // dropped slot; only its leading bit carries the framing bit
      store_o = wr_en_i && (slot_n == 0) && (bit_n == 0);
    end else begin
      store_o = wr_en_i;
      idx_o   = IW'(1 + (slot_n - slot_n / GROUP - 1) * SLOT_BITS + bit_n);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pos_q <= '0;
    else if (restart_i)                   pos_q <= '0;
    else if (wr_en_i) begin
      if (int'(cur_pos) == last_pos)      pos_q <= '0;
      else                                pos_q <= cur_pos + PW'(1);
    end
  end

  // channel block looks at the upcoming bit position
  always_comb begin
    nxt_slot = int'(pos_q) / SLOT_BITS;
    chblk_o  = mode_2m_i && ((nxt_slot % GROUP) == 0);
  end
endmodule

// File: rtl/tx_es_buffer.sv
module tx_es_buffer
  import tx_es_pkg::*;
#(
  parameter int FRAME_BITS = 193,
  parameter int IW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          wr_store_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_data_i,
  input  logic          rd_en_i,
  output logic          line_data_o,
  output logic          line_fbit_o,
  output slip_evt_t     slip_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int DEPTH = 2 * FRAME_BITS;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1) + 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);
  localparam logic [FW-1:0] ONE_FRAME = FW'(FRAME_BITS);

  logic [DEPTH-1:0] mem;
  logic             wr_frame, rd_frame;
  logic [IW-1:0]    rd_idx;
  logic [FW-1:0]    fill, fill_norm, fill_next;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic             wr_last, rd_last;

  always_comb begin
    wr_addr   = wr_frame ? AW'(FRAME_BITS) + AW'(wr_idx_i) : AW'(wr_idx_i);
    rd_addr   = rd_frame ? AW'(FRAME_BITS) + AW'(rd_idx)   : AW'(rd_idx);
    wr_last   = wr_store_i && (wr_idx_i == LAST_IDX);
    rd_last   = rd_en_i && (rd_idx == LAST_IDX);
    fill_norm = fill + FW'(wr_store_i) - FW'(rd_en_i);
    slip_o.full  = wr_last && (fill_norm > ONE_FRAME);
    slip_o.empty = rd_last && (fill_norm < ONE_FRAME);
    fill_next = fill_norm;
    if (slip_o.full)  fill_next = fill_next - ONE_FRAME;
    if (slip_o.empty) fill_next = fill_next + ONE_FRAME;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mem <= '0;
    else if (wr_store_i) mem[wr_addr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_frame <= 1'b0;
      rd_frame <= 1'b1;
      rd_idx   <= '0;
      fill     <= ONE_FRAME;
    end else if (restart_i) begin
      wr_frame <= 1'b0;
      rd_frame <= 1'b1;
      rd_idx   <= '0;
      fill     <= ONE_FRAME;
    end else begin
      if (wr_last && !slip_o.full)  wr_frame <= ~wr_frame;
      if (rd_en_i)                  rd_idx   <= rd_last ? '0 : rd_idx + IW'(1);
      if (rd_last && !slip_o.empty) rd_frame <= ~rd_frame;
      fill <= fill_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_data_o <= 1'b0;
      line_fbit_o <= 1'b0;
    end else if (rd_en_i) begin
      line_data_o <= mem[rd_addr];
      line_fbit_o <= (rd_idx == '0);
    end
  end
endmodule

// File: rtl/tx_es_status.sv
module tx_es_status
  import tx_es_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  slip_evt_t evt_i,
  input  logic      clr_i,
  output logic      slip_o,
  output logic      slip_full_o,
  output logic      slip_empty_o
);
  timeunit 1ns; timeprecision 1ps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slip_o       <= 1'b0;
      slip_full_o  <= 1'b0;
      slip_empty_o <= 1'b0;
    end else begin
      slip_o       <= (slip_o & ~clr_i) | evt_i.full | evt_i.empty;
      slip_full_o  <= (slip_full_o & ~clr_i) | evt_i.full;
      slip_empty_o <= (slip_empty_o & ~clr_i) | evt_i.empty;
    end
  end
endmodule

// File: rtl/tx_elastic_store.sv
module tx_elastic_store
  import tx_es_pkg::*;
#(
  parameter int FRAME_BITS = T1_FRAME_BITS,
  parameter int SLOT_BITS  = SYS_SLOT_BITS,
  parameter int NUM_SLOTS  = SYS_NUM_SLOTS,
  parameter int GROUP      = SYS_DROP_GROUP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_2m_i,
  input  logic wr_en_i,
  input  logic sys_data_i,
  input  logic sys_fsync_i,
  input  logic rd_en_i,
  input  logic es_reset_i,
  input  logic clr_i,
  output logic line_data_o,
  output logic line_fbit_o,
  output logic chblk_o,
  output logic slip_o,
  output logic slip_full_o,
  output logic slip_empty_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IW = $clog2(FRAME_BITS);

  logic          wr_store;
  logic [IW-1:0] wr_idx;
  slip_evt_t     slip_evt;

  tx_es_wr_map #(
    .FRAME_BITS(FRAME_BITS), .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS), .GROUP(GROUP), .IW(IW)
  ) u_map (
    .clk_i, .rst_ni,
    .restart_i (es_reset_i),
    .mode_2m_i,
    .wr_en_i,
    .fsync_i   (sys_fsync_i),
    .store_o   (wr_store),
    .idx_o     (wr_idx),
    .chblk_o
  );

  tx_es_buffer #(.FRAME_BITS(FRAME_BITS), .IW(IW)) u_buf (
    .clk_i, .rst_ni,
    .restart_i  (es_reset_i),
    .wr_store_i (wr_store),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (sys_data_i),
    .rd_en_i,
    .line_data_o,
    .line_fbit_o,
    .slip_o     (slip_evt)
  );

  tx_es_status u_stat (
    .clk_i, .rst_ni,
    .evt_i (slip_evt),
    .clr_i,
    .slip_o,
    .slip_full_o,
    .slip_empty_o
  );
endmodule

// File: rtl/tx_elastic_store_chk.sv
module tx_elastic_store_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic rd_en_i,
  input logic clr_i,
  input logic line_data_o,
  input logic line_fbit_o,
  input logic slip_o,
  input logic slip_full_o,
  input logic slip_empty_o
);
  timeunit 1ns; timeprecision 1ps;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(line_data_o) && $stable(line_fbit_o));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o && !clr_i |=> slip_o);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !wr_en_i && !rd_en_i |=> !slip_o && !slip_full_o && !slip_empty_o);

  assert_full_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_full_o) |-> $past(wr_en_i) && slip_o);

  assert_empty_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_empty_o) |-> $past(rd_en_i) && slip_o);
endmodule

bind tx_elastic_store tx_elastic_store_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .clr_i,
  .line_data_o, .line_fbit_o, .slip_o, .slip_full_o, .slip_empty_o
);

// File: tb/tx_elastic_store_test.sv
module tx_elastic_store_test;
  timeunit 1ns; timeprecision 1ps;

  localparam int FB = 193;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_2m_i = 1'b0, wr_en_i = 1'b0, sys_data_i = 1'b0, sys_fsync_i = 1'b0;
  logic rd_en_i = 1'b0, es_reset_i = 1'b0, clr_i = 1'b0;
  logic line_data_o, line_fbit_o, chblk_o, slip_o, slip_full_o, slip_empty_o;

  always #2.5 clk = ~clk;

  tx_elastic_store uut (
    .clk_i(clk), .rst_ni, .mode_2m_i, .wr_en_i, .sys_data_i, .sys_fsync_i,
    .rd_en_i, .es_reset_i, .clr_i, .line_data_o, .line_fbit_o, .chblk_o,
    .slip_o, .slip_full_o, .slip_empty_o
  );

  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  string cur_req = "R1";
  logic [FB-1:0] pay [0:7];
  logic src [0:2047];
  logic [1:0] exp_q [$];   // {fbit, data}

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: one check per delivered line frame
  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= rd_en_i;

  int bit_cnt = 0, frm_err = 0, frm_no = 0, first_bad = -1;
  logic [1:0] first_got, first_exp;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [1:0] e;
      if (exp_q.size() == 0) e = 2'bxx;
      else e = exp_q.pop_front();
      if ({line_fbit_o, line_data_o} !== e) begin
        if (frm_err == 0) begin
          first_bad = bit_cnt; first_got = {line_fbit_o, line_data_o}; first_exp = e;
        end
        frm_err++;
      end
      bit_cnt++;
      if (bit_cnt == FB) begin
        mon_checks++;
        if (frm_err != 0) begin
          mon_fails++;
          $display("FAIL %s line frame %0d: %0d bad bits, first at %0d got %b expected %b",
                   cur_req, frm_no, frm_err, first_bad, first_got, first_exp);
        end
        frm_no++; bit_cnt = 0; frm_err = 0;
      end
    end
  end

  task automatic do_reset(input logic m2);
    rst_ni = 1'b0; mode_2m_i = m2;
    wr_en_i = 0; rd_en_i = 0; sys_fsync_i = 0; es_reset_i = 0; clr_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic gen_pay(input int first, input int n);
    for (int f = first; f < first + n; f++)
      for (int k = 0; k < FB; k++) pay[f][k] = 1'($urandom_range(1));
  endtask

  // build the system stream from payload frames (R2 / R3 layouts)
  task automatic build_src(input int first, input int n, input logic m2);
    for (int f = 0; f < n; f++) begin
      if (!m2) begin
        for (int k = 0; k < FB; k++) src[f*FB + k] = pay[first+f][k];
      end else begin
        for (int p = 0; p < 256; p++) src[f*256 + p] = 1'($urandom_range(1));
        src[f*256] = pay[first+f][0];
        for (int c = 0; c < 24; c++) begin
          int s = c + c/3 + 1;
          for (int b = 0; b < 8; b++) src[f*256 + s*8 + b] = pay[first+f][1 + 8*c + b];
        end
      end
    end
  endtask

  task automatic push_frame(input int f);
    for (int k = 0; k < FB; k++) exp_q.push_back({k == 0, pay[f][k]});
  endtask

  task automatic push_zero();
    for (int k = 0; k < FB; k++) exp_q.push_back({k == 0, 1'b0});
  endtask

  task automatic run_phase(input int n, input int wn, input int wd,
                           input int rn, input int rdn, input logic m2,
                           input string req);
    int wa = 0, ra = 0, wptr = 0, cb_err = 0, cb_first = -1;
    int flen = m2 ? 256 : FB;
    cur_req = req;
    for (int cyc = 0; cyc < n; cyc++) begin
      bit we = 0, re = 0;
      @(negedge clk);
      wa += wn; if (wa >= wd) begin wa -= wd; we = 1; end
      ra += rn; if (ra >= rdn) begin ra -= rdn; re = 1; end
      sys_fsync_i = 1'b0;
      if (we) begin
        int pos = wptr % flen;
        logic exp_cb = m2 && (((pos / 8) % 4) == 0);
        if (chblk_o !== exp_cb) begin
          if (cb_err == 0) cb_first = pos;
          cb_err++;
        end
        sys_data_i  = src[wptr];
        sys_fsync_i = (pos == 0);
        wptr++;
      end
      wr_en_i = we; rd_en_i = re;
    end
    @(negedge clk);
    wr_en_i = 0; rd_en_i = 0; sys_fsync_i = 0;
    repeat (2) @(negedge clk);
    check(cb_err == 0, m2 ? "R4" : "R2", "channel block mismatches (first pos)", cb_first, -1);
    check(exp_q.size() == 0, req, "expected line bits left undelivered", exp_q.size(), 0);
  endtask

  initial begin
    logic held_d, held_f;
    // R1 reset state
    do_reset(1'b0);
    @(negedge clk);
    check(line_data_o === 0 && line_fbit_o === 0, "R1", "line outputs after reset",
          {line_fbit_o, line_data_o}, 0);
    check({slip_o, slip_full_o, slip_empty_o} === 3'b000, "R8", "flags after reset",
          {slip_o, slip_full_o, slip_empty_o}, 0);
    check(chblk_o === 0, "R2", "chblk in narrow mode after reset", chblk_o, 0);

    // R2: equal rates, narrow mode: zero frame then frames in order
    gen_pay(0, 3); build_src(0, 3, 1'b0);
    push_zero(); push_frame(0); push_frame(1);
    run_phase(3*FB, 1, 1, 1, 1, 1'b0, "R2");
    check({slip_o, slip_full_o, slip_empty_o} === 3'b000, "R6", "no slip at equal rates",
          {slip_o, slip_full_o, slip_empty_o}, 0);

    // R5 hold without read strobes
    held_d = line_data_o; held_f = line_fbit_o;
    repeat (5) @(negedge clk);
    check(line_data_o === held_d && line_fbit_o === held_f, "R5", "line output held",
          {line_fbit_o, line_data_o}, {held_f, held_d});

    // R9: pointer re-centre, reader goes back to frame 1 (holds payload 1)
    es_reset_i = 1'b1; @(negedge clk); es_reset_i = 1'b0;
    gen_pay(3, 2); build_src(3, 2, 1'b0);
    push_frame(1); push_frame(3);
    run_phase(2*FB, 1, 1, 1, 1, 1'b0, "R9");

    // R3 / R4: wide mode, read strobe 193 per 256 cycles
    do_reset(1'b1);
    gen_pay(0, 3); build_src(0, 3, 1'b1);
    push_zero(); push_frame(0); push_frame(1);
    run_phase(3*256, 1, 1, 193, 256, 1'b1, "R3");
    check({slip_o, slip_full_o, slip_empty_o} === 3'b000, "R7", "no slip at matched wide rate",
          {slip_o, slip_full_o, slip_empty_o}, 0);

    // R6: writer twice as fast, every other frame dropped
    do_reset(1'b0);
    gen_pay(0, 6); build_src(0, 6, 1'b0);
    push_zero(); push_frame(1); push_frame(3);
    run_phase(6*FB, 1, 1, 1, 2, 1'b0, "R6");
    check({slip_o, slip_full_o, slip_empty_o} === 3'b110, "R6", "flags after full slips",
          {slip_o, slip_full_o, slip_empty_o}, 3'b110);

    // R8: clear
    clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    check({slip_o, slip_full_o, slip_empty_o} === 3'b000, "R8", "flags after clear",
          {slip_o, slip_full_o, slip_empty_o}, 0);

    // R7: reader twice as fast, every frame repeated
    do_reset(1'b0);
    gen_pay(0, 2); build_src(0, 2, 1'b0);
    push_zero(); push_zero(); push_frame(0); push_frame(0);
    run_phase(4*FB, 1, 2, 1, 1, 1'b0, "R7");
    check({slip_o, slip_full_o, slip_empty_o} === 3'b101, "R7", "flags after empty slips",
          {slip_o, slip_full_o, slip_empty_o}, 3'b101);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", (checks + mon_checks) - (fails + mon_fails),
             checks + mon_checks);
    $finish;
  end

  initial begin
    #500000;
    $display("FAIL R1 watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", (checks + mon_checks) - (fails + mon_fails + 1),
             checks + mon_checks + 1);
    $finish;
  end
endmodule